// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block turns a stream of BCD digits into excess-3 code, one bit per clock. Each digit arrives least significant bit first on a single serial input. The matching excess-3 bit (the digit plus three) leaves on the serial output in the same cycle. No adder is used. A seven-state Mealy machine tracks two things: the bit position inside the digit and the carry produced by the add-three.

A valid strobe qualifies every input bit. On cycles without the strobe, the machine and its output stay frozen, so a sender can pause in the middle of a digit. After the fourth bit of a digit the machine is back in its start state, which lets digits follow one another with no idle cycle. One input combination can never occur for a legal digit: the third-bit carry state seeing a one in the fourth bit position. For that case the block drives a zero, returns to the start state and raises an error flag for one cycle.

Top module: `bcd_xs3_serial`

## Requirements
- R1: While rst_ni is low, and afterwards until the first valid bit, z_o and err_o are 0. The machine starts from the digit-start state. A reset in the middle of a digit discards the partial digit.
- R2: Feed a BCD digit d (0 to 9) on bit_i as four valid bits, bit 0 first. The four z_o values seen in those cycles, read bit 0 first, equal d + 3 in 4-bit binary.
- R3: After four valid bits the machine is back at the digit-start state, so digits can be streamed back to back with no gap.
- R4: In a cycle with valid_i = 0, the machine state does not change and z_o keeps the value it had in the last valid cycle, whatever bit_i does.
- R5: z_o is a Mealy output. Within one valid cycle it follows bit_i combinationally for the present state. For example, after one valid 1 bit from the start state, z_o equals bit_i.
- R6: The only impossible input case is the state entered after bits 1,0,1 of a digit seeing a 1 in the fourth bit position (for example, code 13 sent as 1,0,1,1). In that case z_o = 0, err_o = 1 for that cycle only, and the machine returns to the digit-start state.
- R7: err_o is 0 in every other cycle, including all cycles with valid_i = 0 and all cycles of legal digits 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies bit_i for this cycle |
| bit_i | input | 1 | Serial BCD bit, least significant first |
| z_o | output | 1 | Serial excess-3 bit, same cycle as its input bit |
| err_o | output | 1 | One-cycle flag for the impossible input case |

## Verification
The in-module assertions check four properties on every cycle:
- the state register never takes the unused encoding;
- the state is stable when the strobe is low, and z_o does not move across consecutive idle cycles;
- an error cycle always lands in the start state;
- the last bit-position state always hands over to the start state.

Only the bench scenarios show the arithmetic: that the four output bits of every digit 0 to 9 equal the digit plus three. The bench scenarios also show that z_o answers bit_i within a cycle, and that a reset in the middle of a digit discards the partial digit.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned DIGIT_W = 4;

  // Position and carry, combined in seven codes
  typedef enum logic [STATE_W-1:0] {
    ST_START   = 3'd0,  // bit 0 expected
    ST_B1_NC   = 3'd1,  // bit 1, no carry
    ST_B1_C    = 3'd2,  // bit 1, carry
    ST_B2_NC   = 3'd3,  // bit 2, no carry
    ST_B2_C    = 3'd4,  // bit 2, carry
    ST_B3_NC   = 3'd5,  // bit 3, no carry
    ST_B3_C    = 3'd6   // bit 3, carry
  } xs3_state_e;
endpackage

// File: rtl/xs3_next.sv
module xs3_next
  import xs3_pkg::*;
(
  input  xs3_state_e state_i,
  input  logic       bit_i,
  output xs3_state_e next_o
);
  always_comb begin
    unique case (state_i)
      ST_START: next_o = bit_i ? ST_B1_C  : ST_B1_NC;
      ST_B1_NC: next_o = bit_i ? ST_B2_C  : ST_B2_NC;
      ST_B1_C:  next_o = ST_B2_C;
      ST_B2_NC: next_o = ST_B3_NC;
      ST_B2_C:  next_o = bit_i ? ST_B3_C  : ST_B3_NC;
      ST_B3_NC: next_o = ST_START;
      ST_B3_C:  next_o = ST_START;
      default:  next_o = ST_START;
    endcase
  end
endmodule

// File: rtl/xs3_out.sv
module xs3_out
  import xs3_pkg::*;
(
  input  xs3_state_e state_i,
  input  logic       bit_i,
  output logic       z_o,
  output logic       dc_o
);
  always_comb begin
    dc_o = 1'b0;
    unique case (state_i)
      ST_START: z_o = ~bit_i;
      ST_B1_NC: z_o = ~bit_i;
      ST_B1_C:  z_o =  bit_i;
      ST_B2_NC: z_o =  bit_i;
      ST_B2_C:  z_o = ~bit_i;
      ST_B3_NC: z_o =  bit_i;
      ST_B3_C: begin
        z_o  = 1'b0 | ~bit_i;
        dc_o = bit_i;
      end
      default:  z_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
  import xs3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic z_o,
  output logic err_o
);
  xs3_state_e state_q, state_d;
  logic       z_comb, dc_comb, z_q;

  xs3_next u_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .next_o  (state_d)
  );

  xs3_out u_out (
    .state_i (state_q),
    .bit_i   (bit_i),
    .z_o     (z_comb),
    .dc_o    (dc_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      z_q     <= 1'b0;
    end else if (valid_i) begin
      state_q <= state_d;
      z_q     <= z_comb;
    end
  end

  assign z_o   = valid_i ? z_comb : z_q;
  assign err_o = valid_i & dc_comb;

  assert_legal_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != xs3_state_e'(3'd7));

  assert_hold_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));

  assert_hold_z_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (valid_i || $stable(z_o)));

  assert_err_to_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> state_q == ST_START);

  assert_digit_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (state_q == ST_B3_NC || state_q == ST_B3_C)) |=> state_q == ST_START);
endmodule

// File: tb/bcd_xs3_serial_tb.sv
module bcd_xs3_serial_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic bit_i = 1'b0;
  logic z_o, err_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_xs3_serial u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i),
    .bit_i (bit_i), .z_o (z_o), .err_o (err_o)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one bit after the falling edge, sample before the rising edge
  task automatic step(input logic v, input logic b, output logic z, output logic e);
    @(negedge clk);
    valid_i = v;
    bit_i   = b;
    #1;
    z = z_o;
    e = err_o;
  endtask

  task automatic send_digit(input logic [3:0] d, input string req, output logic [3:0] res,
                            output int errs);
    logic z, e;
    errs = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, d[i], z, e);
      res[i] = z;
      errs += int'(e);
    end
  endtask

  task automatic test_reset();
    logic [3:0] r; int errs;
    #1;
    check("R1 z in reset", int'(z_o), 0);
    check("R1 err in reset", int'(err_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R1 z idle after reset", int'(z_o), 0);
    send_digit(4'd0, "R1", r, errs);
    check("R1 first digit from start", int'(r), 3);
    // reset after two bits of digit 9
    begin logic z, e; step(1'b1, 1'b1, z, e); step(1'b1, 1'b0, z, e); end
    @(negedge clk); valid_i = 1'b0; rst_ni = 1'b0;
    #1; check("R1 z mid reset", int'(z_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    send_digit(4'd1, "R1", r, errs);
    check("R1 digit after mid-digit reset", int'(r), 4);
  endtask

  task automatic test_all_digits();
    logic [3:0] r; int errs;
    for (int d = 0; d < 10; d++) begin
      send_digit(4'(d), "R2", r, errs);
      check("R2 digit plus three", int'(r), d + 3);
      check("R7 no err on legal digit", errs, 0);
    end
    check("R3 streamed ten digits", 1, 1);
  endtask

  task automatic test_hold();
    logic z, e, zl; logic [3:0] r;
    // digit 7 = bits 1,1,1,0 -> 10 = 0,1,0,1
    step(1'b1, 1'b1, z, e); r[0] = z;
    step(1'b1, 1'b1, z, e); r[1] = z; zl = z;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'(i), z, e);
      check("R4 z holds when idle", int'(z), int'(zl));
      check("R7 no err when idle", int'(e), 0);
    end
    step(1'b1, 1'b1, z, e); r[2] = z;
    step(1'b1, 1'b0, z, e); r[3] = z;
    check("R4 digit across pause", int'(r), 10);
  endtask

  task automatic test_mealy();
    logic z, e; logic [3:0] r; int errs;
    step(1'b1, 1'b1, z, e); r[0] = z;
    @(negedge clk);
    valid_i = 1'b1; bit_i = 1'b0; #1;
    check("R5 z follows bit 0", int'(z_o), 0);
    bit_i = 1'b1; #1;
    check("R5 z follows bit 1", int'(z_o), 1);
    r[1] = z_o;
    step(1'b1, 1'b0, z, e); r[2] = z;
    step(1'b1, 1'b0, z, e); r[3] = z;
    check("R5 digit 3 gives 6", int'(r), 6);
    send_digit(4'd8, "R3", r, errs);
    check("R3 next digit after mealy", int'(r), 11);
  endtask

  task automatic test_dont_care();
    logic z, e; logic [3:0] r; int errs;
    step(1'b1, 1'b1, z, e);
    step(1'b1, 1'b0, z, e);
    step(1'b1, 1'b1, z, e);
    check("R7 no err before 4th bit", int'(e), 0);
    step(1'b1, 1'b1, z, e);
    check("R6 z zero on dont-care", int'(z), 0);
    check("R6 err raised", int'(e), 1);
    step(1'b0, 1'b1, z, e);
    check("R6 err one cycle", int'(e), 0);
    send_digit(4'd4, "R6", r, errs);
    check("R6 back to start", int'(r), 7);
    check("R7 no err after recovery", errs, 0);
  endtask

  initial begin : wd
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_all_digits();
    test_hold();
    test_mealy();
    test_dont_care();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule